// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Converter

The block turns a parallel word into a serial bit stream through two register stages. A holding register captures the parallel input whenever its capture strobe is high. A separate shift register takes a copy of the held word when a load control is asserted. On each shift strobe it moves one place toward the serial output. The first stage of the shift register takes a serial input, so several blocks can be chained into one longer stream.

Both strobes are single-cycle enables on one system clock. Because the two registers are separate, a new word can be captured while the previous word is still being shifted out. A clear control empties the shift register at once and leaves the holding register untouched.

Top module: `p2s_dbuf`

## Requirements
- R1: After reset is released, the shift register is zero, so `ser_out` is 0. The holding register is also zero, so a load issued before any capture puts zero in the shift register.
- R2: In a cycle where `cap_en` is 1, the holding register takes `par_in`. At every other cycle it keeps its value.
- R3: In a cycle where `load_n` is 0 and `clr_n` is 1, the shift register takes the holding register value at the next clock edge, whatever `shift_en` is. `ser_out` then shows holding bit W-1.
- R4: In a cycle where `shift_en` is 1, `load_n` is 1 and `clr_n` is 1, the shift register moves one place toward the output. Bit 0 takes `ser_in`. `ser_out` then shows the former bit W-2.
- R5: After a load, successive shifts put the loaded bits on `ser_out` from bit W-1 down to bit 0. The `ser_in` bits supplied with those shifts follow, in order.
- R6: While `clr_n` is 0, `ser_out` is 0 in the same cycle, with no clock edge needed. The shift register is zero after the edge. Clear wins over both load and shift.
- R7: Clear has no effect on the holding register. A load after a clear reproduces the last word captured.
- R8: A capture during a shift sequence does not change the bits being shifted out.
- R9: With both `load_n` and `shift_en` inactive, the shift register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | W | Parallel data word |
| cap_en | input | 1 | Capture strobe for the holding register |
| load_n | input | 1 | Active-low transfer from the holding register to the shift register |
| clr_n | input | 1 | Active-low clear of the shift register |
| shift_en | input | 1 | Shift strobe |
| ser_in | input | 1 | Serial input into the first shift stage |
| ser_out | output | 1 | Serial output from the last shift stage |

## Verification
A corrupted holding register stays hidden until the next load. It then shows at once, on the first bit that goes out. A wrong shift register value shows on `ser_out` within W shifts. A wrong shift direction or a wrong serial-input path shows on the second bit of a stream, or on bit W+1 when blocks are cascaded. A clear that waits for a clock edge shows in the same cycle, as a nonzero `ser_out` while `clr_n` is low.

// File: rtl/p2s_dbuf_pkg.sv
package p2s_dbuf_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } sreg_op_e;
endpackage

// File: rtl/p2s_hold_reg.sv
module p2s_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (cap_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/p2s_op_decode.sv
module p2s_op_decode
  import p2s_dbuf_pkg::*;
(
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     shift_en,
  output sreg_op_e op
);
  always_comb begin
    if (!clr_n)       op = OP_CLEAR;
    else if (!load_n) op = OP_LOAD;
    else if (shift_en) op = OP_SHIFT;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/p2s_shift_reg.sv
module p2s_shift_reg
  import p2s_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sreg_op_e     op,
  input  logic [W-1:0] pdata,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = pdata;
      OP_SHIFT: q_nxt = {q[W-2:0], sin};
      default:  q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/p2s_dbuf.sv
module p2s_dbuf
  import p2s_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  input  logic         cap_en,
  input  logic         load_n,
  input  logic         clr_n,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic         ser_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] hold_q;
  logic [W-1:0] sreg_q;
  sreg_op_e     op;

  p2s_hold_reg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .d(par_in), .q(hold_q)
  );

  p2s_op_decode u_dec (
    .clr_n(clr_n), .load_n(load_n), .shift_en(shift_en), .op(op)
  );

  p2s_shift_reg #(.W(W)) u_sreg (
    .clk(clk), .rst_n(rst_n), .op(op), .pdata(hold_q), .sin(ser_in), .q(sreg_q)
  );

  // the clear acts on the output at once, without waiting for an edge
  assign ser_out = clr_n & sreg_q[MSB];
endmodule

// File: rtl/p2s_dbuf_checker.sv
module p2s_dbuf_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] par_in,
  input logic         cap_en,
  input logic         load_n,
  input logic         clr_n,
  input logic         shift_en,
  input logic         ser_in,
  input logic         ser_out,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] sreg_q
);
  assert_hold_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> hold_q == $past(par_in));
  assert_hold_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(hold_q));
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> sreg_q == $past(hold_q));
  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && shift_en) |=> sreg_q == {$past(sreg_q[W-2:0]), $past(ser_in)});
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> sreg_q == '0);
  assert_clear_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !ser_out);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !shift_en) |=> $stable(sreg_q));
endmodule

bind p2s_dbuf p2s_dbuf_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_en(cap_en), .load_n(load_n),
  .clr_n(clr_n), .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
  .hold_q(hold_q), .sreg_q(sreg_q)
);

// File: tb/p2s_dbuf_test.sv
`timescale 1ns/1ps
module p2s_dbuf_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] par_in = '0;
  logic cap_en = 1'b0, load_n = 1'b1, clr_n = 1'b1, shift_en = 1'b0, ser_in = 1'b0;
  logic ser_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_hold, m_sreg;

  always #2.5 clk = ~clk;

  p2s_dbuf #(.W(W)) uut (.*);

  // independent model of the holding register and the shift register
  function automatic logic [W-1:0] next_sreg(logic [W-1:0] s, logic [W-1:0] h,
                                             logic c, logic l, logic sh, logic si);
    if (!c)      return '0;
    else if (!l) return h;
    else if (sh) return {s[W-2:0], si};
    return s;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ser_out=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs are applied on the falling edge, the model is updated
  // at the rising edge, and ser_out is checked after that edge
  task automatic cyc(string req, logic [W-1:0] p, logic c_en, logic l, logic c,
                     logic sh, logic si);
    par_in = p; cap_en = c_en; load_n = l; clr_n = c; shift_en = sh; ser_in = si;
    #1;
    if (!c) check("R6", ser_out, 1'b0);
    @(posedge clk);
    m_sreg = next_sreg(m_sreg, m_hold, c, l, sh, si);
    if (c_en) m_hold = p;
    @(negedge clk);
    cap_en = 0; load_n = 1; clr_n = 1; shift_en = 0;
    #0.5;
    check(req, ser_out, m_sreg[W-1]);
  endtask

  // load a word, then shift W+2 times: the word goes out MSB first, followed by ser_in bits
  task automatic stream(string req, logic [W-1:0] w, logic [W+1:0] tail);
    cyc("R2", w, 1, 1, 1, 0, 0);
    cyc("R3", '0, 0, 0, 1, 0, 0);
    for (int i = 0; i < W + 2; i++) cyc(req, '0, 0, 1, 1, 1, tail[i]);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_hold = '0;
    m_sreg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    check("R1", ser_out, 1'b0);

    // a load before any capture moves the reset value of the holding register (zero)
    cyc("R1", '0, 0, 0, 1, 0, 0);
    cyc("R1", '0, 0, 1, 1, 1, 0);

    // directed streams
    stream("R5", 8'b1011_0010, 10'b10_0000_0101);
    stream("R5", 8'h80, 10'h3FF);

    // load takes priority over shift
    cyc("R2", 8'h5A, 1, 1, 1, 0, 0);
    cyc("R3", '0, 0, 0, 1, 1, 1);
    for (int i = 0; i < 3; i++) cyc("R4", '0, 0, 1, 1, 1, 1);

    // a capture during shifting does not disturb the bits going out
    cyc("R8", 8'hFF, 1, 1, 1, 1, 0);
    for (int i = 0; i < 4; i++) cyc("R8", '0, 0, 1, 1, 1, 0);

    // with both controls idle, the output holds its value
    for (int i = 0; i < 3; i++) cyc("R9", '0, 0, 1, 1, 0, 1);

    // clear during shifting, with load and shift also asserted; then reload
    cyc("R2", 8'hC3, 1, 1, 1, 0, 0);
    cyc("R3", '0, 0, 0, 1, 0, 0);
    cyc("R6", '0, 0, 0, 0, 1, 1);
    cyc("R6", '0, 0, 1, 1, 1, 0);
    cyc("R7", '0, 0, 0, 1, 0, 0);
    for (int i = 0; i < W; i++) cyc("R7", '0, 0, 1, 1, 1, 0);

    // back-to-back loads
    cyc("R2", 8'h01, 1, 1, 1, 0, 0);
    cyc("R3", 8'hFE, 1, 0, 1, 0, 0);
    cyc("R3", '0, 0, 0, 1, 0, 0);
    cyc("R5", '0, 0, 1, 1, 1, 0);

    // random mix of all controls
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] p;
      logic [3:0] r;
      p = W'($urandom);
      r = 4'($urandom);
      cyc("R4", p, r[0], ($urandom_range(0, 5) != 0), ($urandom_range(0, 15) != 0),
          r[1] | r[2], r[3]);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: time=%0t expected completion", $time);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule